// File: doc/BRIEF.md
# Compute Descriptor Chain Checker

This block watches a stream of 16-byte compute descriptors on their way to a DMA compute engine and decides, per packet, whether the chain is well formed. A packet is a run of descriptors joined by a more-follows bit in the first control word. Its descriptors must come in a fixed order: an optional lead descriptor that loads a seed or a constant, then one or more per-source operation descriptors, then optional replication descriptors that fan the result out to extra destinations. The checker tracks this order across the whole chain. It also enforces the flag that marks the final source, the architecture level needed for fused and replicating packets, the data-type class pairing and the limit on the number of sources.

The checker taps only the two control words of each descriptor (word 0, the link word, and word 1, the operation word). The address and payload words pass beside it. It is always ready once out of reset. One cycle after the descriptor that closes a packet, it raises a one-cycle result strobe with a 3-bit code, where 0 means the packet is accepted. After the first error in a packet, it ignores the remaining descriptors of that packet and starts clean on the next one.

Top module: `desc_chain_checker`

## Requirements
- R1: A packet ends at the first accepted descriptor whose word 0 bit 30 is clear. Exactly one cycle after that descriptor is accepted, `res_valid` is high for one cycle with `res_code`. Code 0 means accept. `res_valid` stays low while more descriptors follow.
- R2: A lead descriptor has word 1 bits [28:23] = 6'b001100 (value 0x0600_0000 with optional constant type bits [22:20]). It must be the first descriptor of its packet. If more descriptors follow it, it must carry the fused-member flag in word 0 bit 26. Otherwise the code is 1.
- R3: These cases give code 1: a source descriptor after a replication descriptor; a replication descriptor before any source; a word 1 bits [28:20] value that matches no role. Source roles are 0x020 (add/min/max), 0x021 (multiply-accumulate), 0x025 (gradient compression) and 0x024 (fused tag). Replication is 0x04A, with its mode in bits [31:29].
- R4: The last flag is word 1 bit 7. Exactly one source in a packet, the final one, must carry it. A packet that closes with no flagged source, a source after a flagged one, or a replication descriptor before any flagged source gives code 2.
- R5: When `cfg_arch` is 2 or less, any lead descriptor, fused-tag source or replication descriptor gives code 3.
- R6: A source descriptor whose input type (word 1 [11:8]) and output type (word 1 [15:12]) are not both inside, or both outside, the range 8..11 gives code 4.
- R7: A 33rd source descriptor in one packet gives code 5. Exactly 32 sources is accepted.
- R8: When one descriptor breaks several rules, the lowest code is reported. The first error in a packet is kept and later descriptors of that packet do not change it. The next packet is judged afresh.
- R9: During reset and on the first cycle after it, `res_valid` is low. From then on `desc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_arch | input | 4 | Architecture level of the target engine |
| desc_valid | input | 1 | Descriptor control words are valid |
| desc_ready | output | 1 | Checker accepts a descriptor this cycle |
| desc_w0 | input | 32 | Link word: bit 30 more-follows, bit 26 fused-member |
| desc_w1 | input | 32 | Operation word: role, types, last flag |
| res_valid | output | 1 | One-cycle strobe: packet verdict available |
| res_code | output | 3 | 0 accept, 1 order, 2 last flag, 3 architecture, 4 type class, 5 source count |

## Verification
The checker is driven with clean chains of increasing shape: one source, three sources, and a full lead-sources-replication chain. These show that well-formed packets of every length pass, and that the strobe appears only after the closing descriptor. Each rule is then broken on its own, including the boundary of 32 against 33 sources and type pairs on each side of the 8..11 range, so each code can be traced to a single cause. Packets that break two rules show which rule wins: two rules in one descriptor, and two errors in separate descriptors of one packet. A clean packet after each failing one shows that the checker starts clean on the next packet.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

   typedef enum logic [2:0] {
      ROLE_LEAD,
      ROLE_SRC,
      ROLE_SRC_FUSED,
      ROLE_REPL,
      ROLE_BAD
   } dcc_role_e;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_ORDER = 3'd1,
      ERR_LAST  = 3'd2,
      ERR_ARCH  = 3'd3,
      ERR_DTYPE = 3'd4,
      ERR_COUNT = 3'd5
   } dcc_err_e;

   typedef struct packed {
      dcc_role_e   role;
      logic        more;
      logic        combo;
      logic        last;
      logic [3:0]  in_dt;
      logic [3:0]  out_dt;
   } dcc_fields_t;

endpackage

// File: rtl/dcc_decode.sv
module dcc_decode
   import dcc_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int MORE_BIT  = 30,
   parameter int COMBO_BIT = 26,
   parameter int LAST_BIT  = 7
) (
   input  logic [WORD_W-1:0] w0,
   input  logic [WORD_W-1:0] w1,
   output dcc_fields_t       fields
);

   localparam logic [8:0] TAG_ACC   = 9'h020;
   localparam logic [8:0] TAG_FMA   = 9'h021;
   localparam logic [8:0] TAG_FUSED = 9'h024;
   localparam logic [8:0] TAG_GRAD  = 9'h025;
   localparam logic [8:0] TAG_REPL  = 9'h04A;
   localparam logic [5:0] TAG_LEAD  = 6'b001100;

   generate
      if (WORD_W != 32) begin : g_bad_width
         $error("dcc_decode: WORD_W must be 32");
      end
   endgenerate

   logic [8:0] tag;
   assign tag = w1[28:20];

   always_comb begin
      if (tag[8:3] == TAG_LEAD)
         fields.role = ROLE_LEAD;
      else if (tag == TAG_ACC || tag == TAG_FMA || tag == TAG_GRAD)
         fields.role = ROLE_SRC;
      else if (tag == TAG_FUSED)
         fields.role = ROLE_SRC_FUSED;
      else if (tag == TAG_REPL)
         fields.role = ROLE_REPL;
      else
         fields.role = ROLE_BAD;
   end

   assign fields.more   = w0[MORE_BIT];
   assign fields.combo  = w0[COMBO_BIT];
   assign fields.last   = w1[LAST_BIT];
   assign fields.in_dt  = w1[11:8];
   assign fields.out_dt = w1[15:12];

   logic unused_bits;
   assign unused_bits = ^{w0[31], w0[29:27], w0[25:0], w1[31:29], w1[19:16], w1[6:0]};

endmodule

// File: rtl/dcc_rules.sv
module dcc_rules
   import dcc_pkg::*;
#(
   parameter int  MAX_SRC     = 32,
   parameter int  CNT_W       = 6,
   parameter int  ARCH_W      = 4,
   parameter int  ARCH_GATE   = 2,
   parameter int  CLASS_LO    = 8,
   parameter int  CLASS_HI    = 11,
   parameter bit  CHECK_COMBO = 1'b1
) (
   input  dcc_fields_t        f,
   input  logic [ARCH_W-1:0]  arch,
   input  logic               first,
   input  logic [CNT_W-1:0]   src_cnt,
   input  logic               last_seen,
   input  logic               repl_seen,
   output dcc_err_e           code
);

   logic is_src;
   logic lead_flag_bad;
   logic bad_order, bad_last, bad_arch, bad_dtype, bad_count;
   logic in_cls, out_cls;

   assign is_src = (f.role == ROLE_SRC) || (f.role == ROLE_SRC_FUSED);

   generate
      if (CHECK_COMBO) begin : g_combo_chk
         assign lead_flag_bad = (f.role == ROLE_LEAD) && f.more && !f.combo;
      end else begin : g_combo_skip
         logic unused_combo;
         assign unused_combo = f.combo;
         assign lead_flag_bad = 1'b0;
      end
   endgenerate

   assign in_cls  = (f.in_dt  >= 4'(CLASS_LO)) && (f.in_dt  <= 4'(CLASS_HI));
   assign out_cls = (f.out_dt >= 4'(CLASS_LO)) && (f.out_dt <= 4'(CLASS_HI));

   assign bad_order = (f.role == ROLE_BAD)
                   || ((f.role == ROLE_LEAD) && !first)
                   || lead_flag_bad
                   || (is_src && repl_seen)
                   || ((f.role == ROLE_REPL) && (src_cnt == '0));

   assign bad_last  = (is_src && last_seen)
                   || ((f.role == ROLE_REPL) && !last_seen)
                   || (!f.more && !(last_seen || (is_src && f.last)));

   assign bad_arch  = (arch <= ARCH_W'(ARCH_GATE))
                   && ((f.role == ROLE_LEAD) || (f.role == ROLE_SRC_FUSED)
                       || (f.role == ROLE_REPL));

   assign bad_dtype = is_src && (in_cls != out_cls);
   assign bad_count = is_src && (src_cnt == CNT_W'(MAX_SRC));

   always_comb begin
      if (bad_order)      code = ERR_ORDER;
      else if (bad_last)  code = ERR_LAST;
      else if (bad_arch)  code = ERR_ARCH;
      else if (bad_dtype) code = ERR_DTYPE;
      else if (bad_count) code = ERR_COUNT;
      else                code = ERR_NONE;
   end

endmodule

// File: rtl/dcc_track.sv
module dcc_track
   import dcc_pkg::*;
#(
   parameter int MAX_SRC = 32,
   parameter int CNT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  dcc_fields_t       f,
   input  dcc_err_e          desc_code,
   output logic              first,
   output logic [CNT_W-1:0]  src_cnt,
   output logic              last_seen,
   output logic              repl_seen,
   output logic              res_valid,
   output logic [2:0]        res_code
);

   dcc_err_e err_q;
   dcc_err_e code_nx;
   logic     is_src;

   assign is_src  = (f.role == ROLE_SRC) || (f.role == ROLE_SRC_FUSED);
   assign code_nx = (err_q != ERR_NONE) ? err_q : desc_code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first     <= 1'b1;
         src_cnt   <= '0;
         last_seen <= 1'b0;
         repl_seen <= 1'b0;
         err_q     <= ERR_NONE;
         res_valid <= 1'b0;
         res_code  <= '0;
      end else begin
         res_valid <= 1'b0;
         if (acc) begin
            if (!f.more) begin
               res_valid <= 1'b1;
               res_code  <= code_nx;
               first     <= 1'b1;
               src_cnt   <= '0;
               last_seen <= 1'b0;
               repl_seen <= 1'b0;
               err_q     <= ERR_NONE;
            end else begin
               first <= 1'b0;
               err_q <= code_nx;
               if (is_src && src_cnt != CNT_W'(MAX_SRC))
                  src_cnt <= src_cnt + 1'b1;
               if (is_src && f.last)
                  last_seen <= 1'b1;
               if (f.role == ROLE_REPL)
                  repl_seen <= 1'b1;
            end
         end
      end
   end

   assert_verdict_after_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(acc && !f.more));

   assert_code_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_code <= 3'd5));

   assert_first_error_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && f.more && err_q != ERR_NONE) |=> (err_q == $past(err_q)));

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      src_cnt <= CNT_W'(MAX_SRC));

endmodule

// File: rtl/desc_chain_checker.sv
module desc_chain_checker
   import dcc_pkg::*;
#(
   parameter int MAX_SRC     = 32,
   parameter int ARCH_W      = 4,
   parameter int ARCH_GATE   = 2,
   parameter int CLASS_LO    = 8,
   parameter int CLASS_HI    = 11,
   parameter bit CHECK_COMBO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ARCH_W-1:0] cfg_arch,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [31:0]       desc_w0,
   input  logic [31:0]       desc_w1,
   output logic              res_valid,
   output logic [2:0]        res_code
);

   localparam int CNT_W = $clog2(MAX_SRC + 1);

   generate
      if (MAX_SRC < 1) begin : g_bad_max
         $error("desc_chain_checker: MAX_SRC must be at least 1");
      end
      if (CLASS_LO > CLASS_HI || CLASS_HI > 15) begin : g_bad_class
         $error("desc_chain_checker: type class range invalid");
      end
   endgenerate

   logic              rdy_q;
   logic              acc;
   dcc_fields_t       fields;
   dcc_err_e          desc_code;
   logic              first;
   logic [CNT_W-1:0]  src_cnt;
   logic              last_seen;
   logic              repl_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) rdy_q <= 1'b0;
      else        rdy_q <= 1'b1;
   end

   assign desc_ready = rdy_q;
   assign acc        = desc_valid && rdy_q;

   dcc_decode u_decode (
      .w0     (desc_w0),
      .w1     (desc_w1),
      .fields (fields)
   );

   dcc_rules #(
      .MAX_SRC     (MAX_SRC),
      .CNT_W       (CNT_W),
      .ARCH_W      (ARCH_W),
      .ARCH_GATE   (ARCH_GATE),
      .CLASS_LO    (CLASS_LO),
      .CLASS_HI    (CLASS_HI),
      .CHECK_COMBO (CHECK_COMBO)
   ) u_rules (
      .f         (fields),
      .arch      (cfg_arch),
      .first     (first),
      .src_cnt   (src_cnt),
      .last_seen (last_seen),
      .repl_seen (repl_seen),
      .code      (desc_code)
   );

   dcc_track #(
      .MAX_SRC (MAX_SRC),
      .CNT_W   (CNT_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .f         (fields),
      .desc_code (desc_code),
      .first     (first),
      .src_cnt   (src_cnt),
      .last_seen (last_seen),
      .repl_seen (repl_seen),
      .res_valid (res_valid),
      .res_code  (res_code)
   );

   assert_ready_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> desc_ready);

endmodule

// File: tb/desc_chain_checker_tb.sv
module desc_chain_checker_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_arch = 4'd3;
   logic        desc_valid = 1'b0;
   logic        desc_ready;
   logic [31:0] desc_w0 = '0;
   logic [31:0] desc_w1 = '0;
   logic        res_valid;
   logic [2:0]  res_code;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_chain_checker u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_arch   (cfg_arch),
      .desc_valid (desc_valid),
      .desc_ready (desc_ready),
      .desc_w0    (desc_w0),
      .desc_w1    (desc_w1),
      .res_valid  (res_valid),
      .res_code   (res_code)
   );

   function automatic logic [31:0] lw(bit more, bit combo);
      return (32'(more) << 30) | (32'(combo) << 26);
   endfunction

   function automatic logic [31:0] ow(int tag, bit last, int in_dt, int out_dt);
      return (32'(tag) << 20) | (32'(last) << 7) | (32'(in_dt) << 8) | (32'(out_dt) << 12);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(logic [31:0] w0, logic [31:0] w1, bit is_end, int exp, string req);
      @(negedge clk);
      desc_valid = 1'b1;
      desc_w0 = w0;
      desc_w1 = w1;
      @(posedge clk);
      #1;
      if (is_end) begin
         chk(res_valid === 1'b1, {req, " strobe"}, int'(res_valid), 1);
         chk(res_code === 3'(exp), {req, " code"}, int'(res_code), exp);
      end else begin
         chk(res_valid === 1'b0, {req, " no strobe mid-packet"}, int'(res_valid), 0);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      desc_valid = 1'b0;
      @(posedge clk);
      #1;
      chk(res_valid === 1'b0, "R1 strobe one cycle", int'(res_valid), 0);
   endtask

   task automatic t_reset();
      chk(res_valid === 1'b0, "R9 res_valid in reset", int'(res_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(res_valid === 1'b0, "R9 res_valid after reset", int'(res_valid), 0);
      @(posedge clk);
      #1;
      chk(desc_ready === 1'b1, "R9 ready", int'(desc_ready), 1);
   endtask

   task automatic t_clean();
      cfg_arch = 4'd2;
      send(lw(0,0), ow('h020, 1, 6, 6), 1, 0, "R1 single source");
      idle();
      send(lw(1,0), ow('h020, 0, 6, 6), 0, 0, "R1 three sources a");
      send(lw(1,0), ow('h021, 0, 6, 6), 0, 0, "R1 three sources b");
      send(lw(0,0), ow('h025, 1, 6, 6), 1, 0, "R1 R4 three sources end");
      idle();
   endtask

   task automatic t_fused();
      cfg_arch = 4'd3;
      send(lw(1,1), ow('h060, 0, 0, 0), 0, 0, "R2 lead");
      send(lw(1,0), ow('h021, 1, 10, 10), 0, 0, "R2 fma");
      send(lw(0,0), ow('h04A, 0, 0, 0) | (32'd3 << 29), 1, 0, "R2 R5 repl accepted arch3");
      idle();
      cfg_arch = 4'd2;
      send(lw(1,1), ow('h060, 0, 0, 0), 0, 0, "R5 lead arch2");
      send(lw(0,0), ow('h020, 1, 6, 6), 1, 3, "R5 lead gated");
      send(lw(1,0), ow('h020, 1, 6, 6), 0, 0, "R5 src");
      send(lw(0,0), ow('h04A, 0, 0, 0), 1, 3, "R5 repl gated");
      send(lw(0,0), ow('h024, 1, 6, 6), 1, 3, "R5 fused tag gated");
      idle();
   endtask

   task automatic t_order();
      cfg_arch = 4'd3;
      send(lw(1,0), ow('h020, 0, 6, 6), 0, 0, "R2 src first");
      send(lw(1,1), ow('h060, 0, 0, 0), 0, 0, "R2 lead second");
      send(lw(0,0), ow('h020, 1, 6, 6), 1, 1, "R2 lead not first");
      send(lw(1,0), ow('h060, 0, 0, 0), 0, 0, "R2 lead no flag");
      send(lw(0,0), ow('h020, 1, 6, 6), 1, 1, "R2 lead missing fused flag");
      send(lw(1,0), ow('h020, 1, 6, 6), 0, 0, "R3 src");
      send(lw(1,0), ow('h04A, 0, 0, 0), 0, 0, "R3 repl");
      send(lw(0,0), ow('h020, 0, 6, 6), 1, 1, "R3 source after replication");
      send(lw(0,0), ow('h04A, 0, 0, 0), 1, 1, "R3 replication before source");
      send(lw(0,0), 32'h0, 1, 1, "R3 unknown role");
      idle();
   endtask

   task automatic t_last();
      cfg_arch = 4'd3;
      send(lw(1,0), ow('h020, 0, 6, 6), 0, 0, "R4 a");
      send(lw(0,0), ow('h020, 0, 6, 6), 1, 2, "R4 missing last");
      send(lw(1,0), ow('h020, 1, 6, 6), 0, 0, "R4 b");
      send(lw(0,0), ow('h020, 1, 6, 6), 1, 2, "R4 duplicate last");
      send(lw(1,0), ow('h020, 0, 6, 6), 0, 0, "R4 c");
      send(lw(0,0), ow('h04A, 0, 0, 0), 1, 2, "R4 repl before last");
      idle();
   endtask

   task automatic t_dtype();
      cfg_arch = 4'd3;
      send(lw(0,0), ow('h020, 1, 10, 6), 1, 4, "R6 mix in32 out16");
      send(lw(0,0), ow('h020, 1, 6, 11), 1, 4, "R6 mix in16 out32");
      send(lw(0,0), ow('h020, 1, 6, 7), 1, 0, "R6 both outside");
      send(lw(0,0), ow('h020, 1, 8, 11), 1, 0, "R6 both inside");
      send(lw(0,0), ow('h020, 1, 12, 7), 1, 0, "R6 just above range");
      idle();
   endtask

   task automatic t_count();
      cfg_arch = 4'd3;
      for (int i = 0; i < 31; i++) send(lw(1,0), ow('h020, 0, 6, 6), 0, 0, "R7 32-run");
      send(lw(0,0), ow('h020, 1, 6, 6), 1, 0, "R7 exactly 32 sources");
      for (int i = 0; i < 32; i++) send(lw(1,0), ow('h020, 0, 6, 6), 0, 0, "R7 33-run");
      send(lw(0,0), ow('h020, 1, 6, 6), 1, 5, "R7 33 sources");
      idle();
   endtask

   task automatic t_priority();
      cfg_arch = 4'd2;
      send(lw(0,0), ow('h024, 1, 10, 6), 1, 3, "R8 arch beats dtype");
      cfg_arch = 4'd3;
      send(lw(1,0), ow('h020, 0, 10, 6), 0, 0, "R8 first error");
      send(lw(1,0), 32'h0, 0, 0, "R8 later error dropped");
      send(lw(0,0), ow('h020, 0, 6, 6), 1, 4, "R8 first error kept");
      send(lw(0,0), ow('h020, 1, 6, 6), 1, 0, "R8 resync clean");
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_clean();
      t_fused();
      t_order();
      t_last();
      t_dtype();
      t_count();
      t_priority();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule